// File: doc/BRIEF.md
# Serial-Fed Two-Channel Pattern Player

This block turns an endless, headerless stream of serial bytes into two digital waveforms, channel A and channel B, that change together. An asynchronous receiver (8 data bits, no parity, one stop bit, least significant bit first) collects bytes. Each byte is cut into four 2-bit samples. A sample timer plays them one after another at four samples per serial frame time, so the output rate follows the line rate exactly.

A one-byte holding register accepts the next byte while the current one plays, so frames sent without gaps give a waveform without gaps. If the holding register is empty when a byte finishes, the outputs keep their last level and a sticky underrun flag goes high. A self-test select replaces the serial stream with an internal byte counter, which is useful for checking output levels and timing with no host attached.

Top module: `pp_pattern_player`

## Requirements
- R1: While reset is high and in the cycle after it, ch_a, ch_b and underrun are all 0.
- R2: The receiver takes frames of one low start bit, 8 data bits sent least significant bit first and one high stop bit, at BAUD bits per second. It samples 16 times per bit, confirms the start bit at mid-bit and samples each data bit at its centre.
- R3: A byte D is played as four samples in the order D[1:0], D[3:2], D[5:4], D[7:6]. In each pair the lower bit drives ch_a and the upper bit drives ch_b, and both outputs change in the same clock cycle.
- R4: Each sample lasts one quarter of a frame time, which is 40 oversample periods (10 bits x 16 / 4). The outputs change only at sample boundaries.
- R5: Frames received back to back play without any gap between bytes, and underrun stays 0.
- R6: When the player is idle, a newly accepted byte starts playing half a bit time after it is accepted.
- R7: When a byte's fourth sample ends and no byte is waiting, ch_a and ch_b hold the fourth sample and underrun becomes 1. Underrun stays 1 until reset, even after playback resumes.
- R8: A frame whose stop bit is low is dropped and does not change the outputs. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: While self_test is 1, the serial line is ignored. The player is fed the values 0, 1, 2, ... of an 8-bit counter, one value per byte slot, starting from 0 after reset, and underrun does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input, idle high, asynchronous to clk |
| self_test | input | 1 | 1 selects the internal counter in place of the serial line |
| ch_a | output | 1 | Channel A output level |
| ch_b | output | 1 | Channel B output level |
| underrun | output | 1 | Sticky flag: a byte ended and no byte was waiting |

## Verification
The properties assume that self_test is changed only while the player is idle or under reset. They also assume that the serial line carries whole frames at the nominal rate, so the holding register is never overwritten before it is read. The stimulus sends frames only from a task that times every bit to exactly one bit period. It sends back-to-back frames only at the nominal rate, and it raises self_test only from idle after a reset. A serial frame sent during self-test is deliberately left on the line; it tests that the line is ignored, not that the receiver works.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
    localparam int OSR          = 16;
    localparam int FRAME_BITS   = 10;
    localparam int PAIRS_PER_BY = 4;

    typedef struct packed {
        logic b;
        logic a;
    } chan_pair_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
    } rx_state_t;

    typedef enum logic [1:0] {
        PL_IDLE, PL_LEAD, PL_PLAY
    } play_state_t;

    function automatic chan_pair_t pick_pair(input logic [7:0] d, input logic [1:0] idx);
        logic [7:0] sh;
        chan_pair_t p;
        sh  = d >> (2 * idx);
        p.a = sh[0];
        p.b = sh[1];
        return p;
    endfunction

    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pp_os_tick.sv
`timescale 1ns/1ps
module pp_os_tick #(
    parameter int DIV = 54
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = pp_pkg::cw(DIV);
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == DW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/pp_uart_rx.sv
`timescale 1ns/1ps
module pp_uart_rx
    import pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_line,
    output logic       valid,
    output logic [7:0] data
);
    localparam logic [3:0] MID  = 4'(OSR / 2 - 1);
    localparam logic [3:0] LAST = 4'(OSR - 1);

    rx_state_t  st;
    logic [1:0] sync;
    logic [3:0] os_cnt;
    logic [2:0] bit_n;
    logic [7:0] sh;
    logic       rx_s;

    assign rx_s = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync   <= 2'b11;
            st     <= RX_IDLE;
            os_cnt <= '0;
            bit_n  <= '0;
            sh     <= '0;
            data   <= '0;
            valid  <= 1'b0;
        end else begin
            sync  <= {sync[0], rx_line};
            valid <= 1'b0;
            case (st)
                RX_IDLE: if (tick && !rx_s) begin
                    st     <= RX_START;
                    os_cnt <= '0;
                end
                RX_START: if (tick) begin
                    if (os_cnt == MID) begin
                        os_cnt <= '0;
                        bit_n  <= '0;
                        st     <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                RX_DATA: if (tick) begin
                    if (os_cnt == LAST) begin
                        os_cnt <= '0;
                        sh     <= {rx_s, sh[7:1]};
                        bit_n  <= bit_n + 1'b1;
                        if (bit_n == 3'd7) st <= RX_STOP;
                    end else begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (os_cnt == LAST) begin
                        os_cnt <= '0;
                        if (rx_s) begin
                            data  <= sh;
                            valid <= 1'b1;
                            st    <= RX_IDLE;
                        end else begin
                            st <= RX_WAIT_HIGH;
                        end
                    end else begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                RX_WAIT_HIGH: if (rx_s) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pp_player.sv
`timescale 1ns/1ps
module pp_player
    import pp_pkg::*;
#(
    parameter int SMP_CLKS  = 2160,
    parameter int LEAD_CLKS = 432
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] push_data,
    output logic       buf_full,
    output chan_pair_t pair_out,
    output logic       strobe,
    output logic       underrun
);
    localparam int CW = cw(SMP_CLKS > LEAD_CLKS ? SMP_CLKS : LEAD_CLKS);
    localparam logic [1:0] LAST_IDX = 2'(PAIRS_PER_BY - 1);

    play_state_t   st;
    logic [CW-1:0] cnt;
    logic [1:0]    idx;
    logic [7:0]    act;
    logic [7:0]    hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PL_IDLE;
            cnt      <= '0;
            idx      <= '0;
            act      <= '0;
            hold     <= '0;
            buf_full <= 1'b0;
            pair_out <= '0;
            strobe   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (push) begin
                hold     <= push_data;
                buf_full <= 1'b1;
            end
            case (st)
                PL_IDLE: if (buf_full) begin
                    st  <= PL_LEAD;
                    cnt <= '0;
                end
                PL_LEAD: begin
                    if (cnt == CW'(LEAD_CLKS - 1)) begin
                        act      <= hold;
                        buf_full <= push;
                        pair_out <= pick_pair(hold, 2'd0);
                        strobe   <= 1'b1;
                        idx      <= '0;
                        cnt      <= '0;
                        st       <= PL_PLAY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PL_PLAY: begin
                    if (cnt == CW'(SMP_CLKS - 1)) begin
                        cnt <= '0;
                        if (idx != LAST_IDX) begin
                            idx      <= idx + 2'd1;
                            pair_out <= pick_pair(act, idx + 2'd1);
                            strobe   <= 1'b1;
                        end else if (buf_full) begin
                            act      <= hold;
                            buf_full <= push;
                            pair_out <= pick_pair(hold, 2'd0);
                            strobe   <= 1'b1;
                            idx      <= '0;
                        end else begin
                            st       <= PL_IDLE;
                            underrun <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= PL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pp_pattern_player.sv
`timescale 1ns/1ps
module pp_pattern_player
    import pp_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_line,
    input  logic self_test,
    output logic ch_a,
    output logic ch_b,
    output logic underrun
);
    localparam int DIV       = (CLK_HZ / (BAUD * OSR)) > 0 ? CLK_HZ / (BAUD * OSR) : 1;
    localparam int BIT_CLKS  = DIV * OSR;
    localparam int SMP_CLKS  = BIT_CLKS * FRAME_BITS / PAIRS_PER_BY;
    localparam int LEAD_CLKS = BIT_CLKS / 2;

    logic       os_tick;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       buf_full;
    logic       smp_strobe;
    logic       st_push;
    logic [7:0] st_cnt;
    logic       push;
    logic [7:0] push_data;
    chan_pair_t pair;

    pp_os_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick)
    );

    pp_uart_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .rx_line (rx_line),
        .valid   (rx_valid),
        .data    (rx_data)
    );

    assign st_push   = self_test && !buf_full;
    assign push      = self_test ? st_push : rx_valid;
    assign push_data = self_test ? st_cnt : rx_data;

    always_ff @(posedge clk) begin
        if (rst)          st_cnt <= '0;
        else if (st_push) st_cnt <= st_cnt + 8'd1;
    end

    pp_player #(.SMP_CLKS(SMP_CLKS), .LEAD_CLKS(LEAD_CLKS)) u_play (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .buf_full  (buf_full),
        .pair_out  (pair),
        .strobe    (smp_strobe),
        .underrun  (underrun)
    );

    assign ch_a = pair.a;
    assign ch_b = pair.b;
endmodule

// File: rtl/pp_pattern_player_chk.sv
`timescale 1ns/1ps
module pp_pattern_player_chk (
    input logic clk,
    input logic rst,
    input logic self_test,
    input logic ch_a,
    input logic ch_b,
    input logic underrun,
    input logic strobe,
    input logic rx_valid
);
    p_outs_only_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> $stable({ch_a, ch_b}));

    p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    p_underrun_no_new_sample_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> !strobe && $stable({ch_a, ch_b}));

    p_selftest_no_underrun_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> !self_test);

    p_rx_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind pp_pattern_player pp_pattern_player_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .self_test (self_test),
    .ch_a      (ch_a),
    .ch_b      (ch_b),
    .underrun  (underrun),
    .strobe    (smp_strobe),
    .rx_valid  (rx_valid)
);

// File: tb/pp_pattern_player_bench.sv
`timescale 1ns/1ps
module pp_pattern_player_bench;
    localparam int BIT  = 64;
    localparam int SMP  = 160;
    localparam int FRM  = 640;
    localparam int MID0 = 728;
    localparam int NV   = 7;
    // {byte, expected A samples (sample 0 in bit 0), expected B samples}
    localparam logic [15:0] VEC [NV] = '{
        {8'h1B, 4'b0101, 4'b0011},
        {8'hE4, 4'b1010, 4'b1100},
        {8'h55, 4'b1111, 4'b0000},
        {8'hAA, 4'b0000, 4'b1111},
        {8'hFF, 4'b1111, 4'b1111},
        {8'h00, 4'b0000, 4'b0000},
        {8'h9C, 4'b0110, 4'b1010}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_line = 1'b1;
    logic self_test = 1'b0;
    logic ch_a, ch_b, underrun;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    pp_pattern_player #(.CLK_HZ(100_000_000), .BAUD(1_562_500)) u_pp_pattern_player (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .self_test (self_test),
        .ch_a      (ch_a),
        .ch_b      (ch_b),
        .underrun  (underrun)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic stop_bit);
        rx_line = 1'b0;
        repeat (BIT) @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (BIT) @(posedge clk);
            #1;
        end
        rx_line = stop_bit;
        repeat (BIT) @(posedge clk);
        #1;
        rx_line = 1'b1;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        cyc(3);
        chk("R1 reset ch_a", ch_a, 1'b0);
        chk("R1 reset ch_b", ch_b, 1'b0);
        chk("R1 reset underrun", underrun, 1'b0);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        cyc(1);
        chk("R1 after reset ch_a", ch_a, 1'b0);
        chk("R1 after reset underrun", underrun, 1'b0);
        cyc(20);

        // R2 R3 R4 R5 R6: back-to-back frames from the vector table
        @(posedge clk);
        #1;
        fork
            begin
                for (int v = 0; v < NV; v++) send_byte(VEC[v][15:8], 1'b1);
            end
            begin
                cyc(MID0 - 1);
                for (int v = 0; v < NV; v++) begin
                    for (int k = 0; k < 4; k++) begin
                        chk((v == 0 && k == 0) ? "R6 first sample after lead" : "R3 R2 ch_a",
                            ch_a, VEC[v][4 + k]);
                        chk("R3 R4 ch_b", ch_b, VEC[v][k]);
                        chk("R5 no underrun during stream", underrun, 1'b0);
                        cyc(SMP);
                    end
                end
            end
        join

        // R7: starved player holds last sample, flag set
        cyc(300);
        chk("R7 underrun set", underrun, 1'b1);
        chk("R7 hold ch_a", ch_a, 1'b0);
        chk("R7 hold ch_b", ch_b, 1'b1);

        // R8: frame with low stop bit is dropped
        send_byte(8'hFF, 1'b0);
        cyc(FRM + 400);
        chk("R8 dropped ch_a", ch_a, 1'b0);
        chk("R8 dropped ch_b", ch_b, 1'b1);

        // R8 recovery and R7 stickiness
        @(posedge clk);
        #1;
        fork
            send_byte(8'h55, 1'b1);
            begin
                cyc(MID0 - 1);
                for (int k = 0; k < 4; k++) begin
                    chk("R8 recovered ch_a", ch_a, 1'b1);
                    chk("R8 recovered ch_b", ch_b, 1'b0);
                    chk("R7 underrun sticky", underrun, 1'b1);
                    cyc(SMP);
                end
            end
        join

        do_reset();

        // R9: self-test counter feeds player; serial traffic ignored
        cyc(10);
        @(posedge clk);
        #1;
        self_test = 1'b1;
        fork
            send_byte(8'hFF, 1'b1);
            begin
                cyc(114 - 1);
                for (int n = 0; n < 4; n++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] sh;
                        sh = 8'(n) >> (2 * k);
                        chk("R9 self-test ch_a", ch_a, sh[0]);
                        chk("R9 self-test ch_b", ch_b, sh[1]);
                        chk("R9 self-test no underrun", underrun, 1'b0);
                        cyc(SMP);
                    end
                end
            end
        join

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule